// File: doc/BRIEF.md
# Banked GPIO Expander Register File

This block is the register core of a byte-addressed GPIO port expander for 20, 40 or 60 pins, arranged as up to eight 8-bit ports. A plain synchronous register bus reaches it. The bus has an address, write data, a write strobe, a read strobe and registered read data. Each pin holds four pieces of state: an output level, a direction, a polarity-invert bit and a drive mode. From that state the block drives a level, an output enable and a 3-bit drive-mode code for each pad.

Two kinds of register are visible. The input-level and output-level registers each have one address per port. Interrupt mask, polarity invert, direction and the seven drive-mode registers share a single address each. That address acts on whichever port the port-select register names. The drive-mode registers are set-only and mutually exclusive: writing a 1 moves the pin into that mode and out of every other mode.

Top module: `gpx_regfile`

## Requirements
- R1: After reset:
  - every pin is an input, so `pin_oe` is 0;
  - every output level is 0 and every invert bit is 0;
  - every pin's drive code is 4 (strong fast);
  - port select is 0 and `bus_rdata` is 0.
- R2: On the clock edge where `bus_re` is 1, `bus_rdata` loads the value at `bus_addr`. While `bus_re` is 0, `bus_rdata` holds its value.
- R3: Address 0x00+p returns the pad levels of port p, each XORed with that pin's invert bit. Writes to 0x00–0x07 have no effect.
- R4: Address 0x08+p reads and writes the output levels of port p. `pin_out` follows the stored bits.
- R5: Pin n maps to bit position n when n < 20, and to n+4 otherwise. Position q is bit q%8 of port q/8. Bits 4–7 of port 2 always read 0 and ignore writes.
- R6: Address 0x18 holds the port select. A written value above the last implemented port is stored as the last port (7 for 60 pins).
- R7: The windows act only on the selected port: 0x19 (interrupt mask), 0x1B (invert) and 0x1C (direction).
- R8: A direction bit of 1 makes the pin an input with `pin_oe` 0. A direction bit of 0 makes it an output.
- R9: Addresses 0x1D–0x23 are the drive-mode windows for codes 0–6 in order:
  - 0 pull-up, 1 pull-down, 2 open-drain high, 3 open-drain low;
  - 4 strong fast, 5 strong slow, 6 high-impedance.
  
  A written 1 selects that mode for the pin and clears the bit in every other mode. A written 0 changes nothing. A read returns 1 for the pins currently in that mode.
- R10: `pin_drive[3n+2:3n]` carries pin n's drive code.
- R11: For an output pin:
  - the pull modes and the strong modes enable the pad;
  - open-drain high enables it only when the level is 1;
  - open-drain low enables it only when the level is 0;
  - high-impedance never enables it.
- R12: Address 0x2E reads the device ID, whose upper nibble is NUM_PINS/10 (0x60 by default). Writes to it have no effect.
- R13: Unused addresses, unused bits and unimplemented ports read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | NUM_PINS | Pad input levels |
| pin_out | output | NUM_PINS | Pad output levels |
| pin_oe | output | NUM_PINS | Pad output enables |
| pin_drive | output | 3*NUM_PINS | Drive-mode code per pin |

## Verification
A wrong drive mode or direction shows up at `pin_oe` and `pin_drive` in the same cycle as the write edge that caused it. Those outputs depend on state only through gates. A wrong output level shows at `pin_out` at once. Corrupted select, invert or mask state appears on `bus_rdata` one cycle after the read strobe. Writing a drive mode on one port and then reading every drive window exposes any missed clear or any leak into another port.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    typedef enum logic [3:0] {
        RG_NONE, RG_IN, RG_OUT, RG_SEL, RG_MASK, RG_INV, RG_DIR, RG_DRV, RG_ID
    } region_e;

    localparam logic [7:0] A_SEL     = 8'h18;
    localparam logic [7:0] A_MASK    = 8'h19;
    localparam logic [7:0] A_INV     = 8'h1B;
    localparam logic [7:0] A_DIR     = 8'h1C;
    localparam logic [7:0] A_DRV_LO  = 8'h1D;
    localparam logic [7:0] A_DRV_HI  = 8'h23;
    localparam logic [7:0] A_ID      = 8'h2E;

    localparam logic [2:0] DM_PULLUP = 3'd0;
    localparam logic [2:0] DM_PULLDN = 3'd1;
    localparam logic [2:0] DM_ODHI   = 3'd2;
    localparam logic [2:0] DM_ODLO   = 3'd3;
    localparam logic [2:0] DM_FAST   = 3'd4;
    localparam logic [2:0] DM_SLOW   = 3'd5;
    localparam logic [2:0] DM_HIZ    = 3'd6;

    // bit position of a linear pin: port 2 has a four-bit gap
    function automatic int pin_pos(input int n);
        return (n >= 20) ? n + 4 : n;
    endfunction

    // which bits of a port carry a real pin
    function automatic logic [7:0] port_used(input int port, input int npins);
        logic [7:0] u;
        for (int b = 0; b < 8; b++) begin
            int pos;
            pos = port * 8 + b;
            if (pos < 20) u[b] = (pos < npins);
            else          u[b] = (pos >= 24) && (pos - 4 < npins);
        end
        return u;
    endfunction

    function automatic logic pad_oe(input logic dir_in, input logic [2:0] mode,
                                    input logic lvl);
        if (dir_in) return 1'b0;
        case (mode)
            DM_ODHI: return lvl;
            DM_ODLO: return !lvl;
            DM_HIZ:  return 1'b0;
            default: return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/gpx_decode.sv
module gpx_decode
    import gpx_pkg::*;
(
    input  logic [7:0] addr,
    output region_e    region,
    output logic [2:0] idx
);
    always_comb begin
        idx = addr[2:0];
        unique case (1'b1)
            (addr[7:3] == 5'b00000):                 region = RG_IN;
            (addr[7:3] == 5'b00001):                 region = RG_OUT;
            (addr == A_SEL):                         region = RG_SEL;
            (addr == A_MASK):                        region = RG_MASK;
            (addr == A_INV):                         region = RG_INV;
            (addr == A_DIR):                         region = RG_DIR;
            (addr >= A_DRV_LO && addr <= A_DRV_HI): begin
                region = RG_DRV;
                idx    = 3'(addr - A_DRV_LO);
            end
            (addr == A_ID):                          region = RG_ID;
            default:                                 region = RG_NONE;
        endcase
    end
endmodule

// File: rtl/gpx_port.sv
module gpx_port
    import gpx_pkg::*;
#(
    parameter int PORT     = 0,
    parameter int NUM_PINS = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  wdata,
    input  logic        wr_out,
    input  logic        wr_msk,
    input  logic        wr_inv,
    input  logic        wr_dir,
    input  logic        wr_drv,
    input  logic [2:0]  drv_sel,
    output logic [7:0]  out_q,
    output logic [7:0]  msk_q,
    output logic [7:0]  inv_q,
    output logic [7:0]  dir_q,
    output logic [23:0] mode_flat,
    output logic [7:0]  drv_rd
);
    localparam logic [7:0] USED = port_used(PORT, NUM_PINS);

    logic [2:0] mode_q [8];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            msk_q <= '0;
            inv_q <= '0;
            dir_q <= USED;
        end else begin
            if (wr_out) out_q <= wdata & USED;
            if (wr_msk) msk_q <= wdata & USED;
            if (wr_inv) inv_q <= wdata & USED;
            if (wr_dir) dir_q <= wdata & USED;
        end
    end

    for (genvar b = 0; b < 8; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_q[b] <= DM_FAST;
            else if (wr_drv && wdata[b] && USED[b])
                mode_q[b] <= drv_sel;
        end
        assign mode_flat[b*3 +: 3] = mode_q[b];
        assign drv_rd[b] = USED[b] && (mode_q[b] == drv_sel);

        // R9
        drv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_drv && wdata[b] && USED[b]) |=> (mode_q[b] == $past(drv_sel)));
        // R9
        drv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_drv && !wdata[b]) |=> $stable(mode_q[b]));
    end
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter int NUM_PINS = 60
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            bus_addr,
    input  logic [7:0]            bus_wdata,
    input  logic                  bus_we,
    input  logic                  bus_re,
    output logic [7:0]            bus_rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [3*NUM_PINS-1:0] pin_drive
);
    localparam int         NBITS     = (NUM_PINS > 20) ? NUM_PINS + 4 : NUM_PINS;
    localparam int         NPORTS    = (NBITS + 7) / 8;
    localparam int         LAST_PORT = NPORTS - 1;
    localparam logic [7:0] DEV_ID    = 8'((NUM_PINS / 10) << 4);

    region_e    region;
    logic [2:0] idx;
    logic [2:0] sel_q;
    logic [7:0] rd_val;
    logic [63:0] in_pos;
    logic [63:0] out_pos;
    logic [63:0] dir_pos;
    logic [7:0]  out_w [8];
    logic [7:0]  msk_w [8];
    logic [7:0]  inv_w [8];
    logic [7:0]  dir_w [8];
    logic [7:0]  drv_w [8];
    logic [23:0] mode_w [8];

    gpx_decode u_dec (.addr(bus_addr), .region(region), .idx(idx));

    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (bus_we && region == RG_SEL)
            sel_q <= (bus_wdata > 8'(LAST_PORT)) ? 3'(LAST_PORT) : bus_wdata[2:0];
    end

    for (genvar p = 0; p < 8; p++) begin : g_port
        if (p < NPORTS) begin : g_on
            gpx_port #(.PORT(p), .NUM_PINS(NUM_PINS)) u_port (
                .clk      (clk),
                .rst_n    (rst_n),
                .wdata    (bus_wdata),
                .wr_out   (bus_we && region == RG_OUT && idx == 3'(p)),
                .wr_msk   (bus_we && region == RG_MASK && sel_q == 3'(p)),
                .wr_inv   (bus_we && region == RG_INV && sel_q == 3'(p)),
                .wr_dir   (bus_we && region == RG_DIR && sel_q == 3'(p)),
                .wr_drv   (bus_we && region == RG_DRV && sel_q == 3'(p)),
                .drv_sel  (idx),
                .out_q    (out_w[p]),
                .msk_q    (msk_w[p]),
                .inv_q    (inv_w[p]),
                .dir_q    (dir_w[p]),
                .mode_flat(mode_w[p]),
                .drv_rd   (drv_w[p])
            );
        end else begin : g_off
            assign out_w[p]  = '0;
            assign msk_w[p]  = '0;
            assign inv_w[p]  = '0;
            assign dir_w[p]  = '0;
            assign drv_w[p]  = '0;
            assign mode_w[p] = {8{DM_FAST}};
        end
        assign out_pos[p*8 +: 8] = out_w[p];
        assign dir_pos[p*8 +: 8] = dir_w[p];
    end

    always_comb begin
        in_pos = '0;
        for (int n = 0; n < NUM_PINS; n++) begin
            in_pos[pin_pos(n)]  = pin_in[n];
            pin_out[n]          = out_pos[pin_pos(n)];
            pin_drive[3*n +: 3] = mode_w[pin_pos(n) / 8][(pin_pos(n) % 8) * 3 +: 3];
            pin_oe[n]           = pad_oe(dir_pos[pin_pos(n)], pin_drive[3*n +: 3],
                                         out_pos[pin_pos(n)]);
        end
    end

    always_comb begin
        unique case (region)
            RG_IN:   rd_val = (in_pos[{idx, 3'b000} +: 8] ^ inv_w[idx])
                              & port_used(int'(idx), NUM_PINS);
            RG_OUT:  rd_val = out_w[idx];
            RG_SEL:  rd_val = {5'b0, sel_q};
            RG_MASK: rd_val = msk_w[sel_q];
            RG_INV:  rd_val = inv_w[sel_q];
            RG_DIR:  rd_val = dir_w[sel_q];
            RG_DRV:  rd_val = drv_w[sel_q];
            RG_ID:   rd_val = DEV_ID;
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_val;
    end

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));
    // R6
    sel_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SEL && bus_wdata > 8'(LAST_PORT))
        |=> (sel_q == 3'(LAST_PORT)));
    // R12
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == A_ID) |=> (bus_rdata == DEV_ID));
    // R3
    in_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[7:3] == 5'b00000) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/tb_gpx_regfile.sv
module tb_gpx_regfile;
    localparam int NP = 60;
    localparam int NV = 41;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic bus_we = 1'b0, bus_re = 1'b0;
    logic [NP-1:0] pin_in = 60'h00000000_81F3CA5;
    logic [NP-1:0] pin_out, pin_oe;
    logic [3*NP-1:0] pin_drive;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    gpx_regfile #(.NUM_PINS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_drive(pin_drive)
    );

    // {read, req, addr, wdata, expected}
    localparam logic [28:0] VEC [NV] = '{
        {1'b1, 4'd3,  8'h00, 8'h00, 8'hA5},  // R3
        {1'b1, 4'd3,  8'h01, 8'h00, 8'h3C},
        {1'b1, 4'd5,  8'h02, 8'h00, 8'h0F},  // R5 gap bits
        {1'b1, 4'd3,  8'h03, 8'h00, 8'h81},
        {1'b0, 4'd3,  8'h00, 8'hFF, 8'h00},  // R3 write ignored
        {1'b1, 4'd3,  8'h00, 8'h00, 8'hA5},
        {1'b0, 4'd4,  8'h09, 8'h5A, 8'h00},  // R4
        {1'b1, 4'd4,  8'h09, 8'h00, 8'h5A},
        {1'b0, 4'd5,  8'h0A, 8'hFF, 8'h00},
        {1'b1, 4'd5,  8'h0A, 8'h00, 8'h0F},
        {1'b0, 4'd6,  8'h18, 8'h03, 8'h00},  // R6
        {1'b1, 4'd6,  8'h18, 8'h00, 8'h03},
        {1'b0, 4'd7,  8'h1B, 8'hFF, 8'h00},  // R7 invert port 3
        {1'b1, 4'd3,  8'h03, 8'h00, 8'h7E},
        {1'b1, 4'd7,  8'h00, 8'h00, 8'hA5},
        {1'b0, 4'd6,  8'h18, 8'h0A, 8'h00},  // R6 clip
        {1'b1, 4'd6,  8'h18, 8'h00, 8'h07},
        {1'b1, 4'd7,  8'h1C, 8'h00, 8'hFF},
        {1'b0, 4'd7,  8'h1C, 8'h00, 8'h00},
        {1'b1, 4'd7,  8'h1C, 8'h00, 8'h00},
        {1'b0, 4'd7,  8'h18, 8'h03, 8'h00},
        {1'b1, 4'd7,  8'h1C, 8'h00, 8'hFF},
        {1'b1, 4'd7,  8'h1B, 8'h00, 8'hFF},
        {1'b0, 4'd7,  8'h19, 8'hC3, 8'h00},
        {1'b1, 4'd7,  8'h19, 8'h00, 8'hC3},
        {1'b1, 4'd9,  8'h21, 8'h00, 8'hFF},  // R9
        {1'b0, 4'd9,  8'h1D, 8'h0F, 8'h00},
        {1'b1, 4'd9,  8'h1D, 8'h00, 8'h0F},
        {1'b1, 4'd9,  8'h21, 8'h00, 8'hF0},
        {1'b0, 4'd9,  8'h20, 8'h11, 8'h00},
        {1'b1, 4'd9,  8'h20, 8'h00, 8'h11},
        {1'b1, 4'd9,  8'h1D, 8'h00, 8'h0E},
        {1'b1, 4'd9,  8'h21, 8'h00, 8'hE0},
        {1'b0, 4'd9,  8'h21, 8'h00, 8'h00},
        {1'b1, 4'd9,  8'h21, 8'h00, 8'hE0},
        {1'b1, 4'd12, 8'h2E, 8'h00, 8'h60},  // R12
        {1'b0, 4'd12, 8'h2E, 8'hFF, 8'h00},
        {1'b1, 4'd12, 8'h2E, 8'h00, 8'h60},
        {1'b1, 4'd13, 8'h1A, 8'h00, 8'h00},  // R13
        {1'b1, 4'd13, 8'h10, 8'h00, 8'h00},
        {1'b1, 4'd13, 8'h30, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 oe", 64'(pin_oe), 64'h0);
        check("R1 out", 64'(pin_out), 64'h0);
        check("R1 rdata", 64'(bus_rdata), 64'h0);
        for (int n = 0; n < NP; n++)
            if (pin_drive[3*n +: 3] !== 3'd4) check("R1 drive", 64'(pin_drive[3*n +: 3]), 64'd4);
        checks++;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][28]) begin
                bus_rd(VEC[i][23:16], d);
                checks++;
                if (d !== VEC[i][7:0]) begin
                    errors++;
                    $display("FAIL R%0d vec %0d addr=%0h actual=%0h expected=%0h",
                             VEC[i][27:24], i, VEC[i][23:16], d, VEC[i][7:0]);
                end
            end else begin
                bus_wr(VEC[i][23:16], VEC[i][15:8]);
            end
        end

        // R4 pin_out follows output registers, R5 gap bits do not leak
        check("R4 pin_out port1", 64'(pin_out[15:8]), 64'h5A);
        check("R5 pin_out port2", 64'(pin_out[19:16]), 64'hF);
        check("R5 pin_out port3", 64'(pin_out[27:20]), 64'h0);
        // R8 port 7 made output, strong fast, level 0
        check("R8 port7 oe", 64'(pin_oe[59:52]), 64'hFF);
        check("R8 port3 input", 64'(pin_oe[27:20]), 64'h0);

        // R11 modes on port 1 (levels 5A)
        bus_wr(8'h18, 8'h01);
        bus_wr(8'h1C, 8'h00);
        check("R11 strong oe", 64'(pin_oe[15:8]), 64'hFF);
        bus_wr(8'h1F, 8'hFF);
        check("R11 od-high oe", 64'(pin_oe[15:8]), 64'h5A);
        check("R10 drive pin8 od-high", 64'(pin_drive[26:24]), 64'd2);
        bus_wr(8'h20, 8'hFF);
        check("R11 od-low oe", 64'(pin_oe[15:8]), 64'hA5);
        bus_wr(8'h23, 8'hFF);
        check("R11 hiz oe", 64'(pin_oe[15:8]), 64'h00);
        check("R10 drive pin15 hiz", 64'(pin_drive[47:45]), 64'd6);
        bus_wr(8'h1D, 8'hFF);
        check("R11 pull-up oe", 64'(pin_oe[15:8]), 64'hFF);
        check("R10 drive pin8 pull-up", 64'(pin_drive[26:24]), 64'd0);
        bus_wr(8'h1C, 8'hFF);
        check("R8 back to input", 64'(pin_oe[15:8]), 64'h00);

        // R2 read data holds without a read strobe
        bus_rd(8'h2E, d);
        check("R2 read", 64'(d), 64'h60);
        @(negedge clk);
        bus_addr = 8'h00;
        repeat (2) @(negedge clk);
        check("R2 hold", 64'(bus_rdata), 64'h60);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule